// File: doc/BRIEF.md
# Four-Mode Binary Rounding Unit

This block shortens a sign-magnitude significand that carries extra low-order bits down to a fixed number of fraction bits. It can round to nearest with ties going to an even result, round toward minus infinity, round toward plus infinity, or truncate toward zero. The direction of any increment depends on both the sign and the mode. Rounding toward an infinity therefore grows the magnitude of a negative value only when the target is minus infinity.

The result comes with an inexact flag. It also comes with a carry-out that tells the exponent logic downstream to renormalise when an increment overflows the kept significand. Operands enter and results leave on valid/ready streams with one register stage. An input beat is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a stalled consumer stops the producer through back-pressure. The result stays frozen while `out_valid` is high and `out_ready` is low. The mode pin is a plain control input and is sampled together with each accepted beat.

Top module: `round_unit`

## Requirements
- R1: The 2-bit mode encodes 00 = nearest-even (the reset-time default a host would load), 01 = toward minus infinity, 10 = toward plus infinity, 11 = toward zero, and it is sampled with each accepted beat.
- R2: When every discarded bit is zero, the output significand equals the kept input bits, and inexact and carry are 0 in every mode.
- R3: In nearest-even mode the kept bits are the top SIG_W bits of `in_mag`, the round bit is the next bit below, and sticky is the OR of all lower bits. The magnitude is incremented when round=1 and sticky=1. It is left alone when round=0. On an exact half (round=1, sticky=0) it is incremented only if the kept LSB is 1.
- R4: In toward-zero mode the output is the kept bits unchanged and carry is 0.
- R5: In toward-plus-infinity mode an inexact positive value has its magnitude incremented by one LSB, and an inexact negative value is truncated.
- R6: In toward-minus-infinity mode an inexact negative value has its magnitude incremented by one LSB, and an inexact positive value is truncated.
- R7: `out_inexact` is the OR of all discarded bits, whatever the mode.
- R8: If an increment overflows an all-ones kept significand, `out_carry` is 1 and `out_sig` is 1 followed by SIG_W-1 zeros. Otherwise `out_carry` is 0.
- R9: `out_sign` equals the sign of the accepted beat.
- R10: A result appears with `out_valid` in the cycle after its beat is accepted. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, all output fields hold. Input fields are ignored when `in_valid` is low.
- R11: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rnd_mode | input | 2 | Rounding mode, sampled with an accepted beat |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be taken |
| in_sign | input | 1 | Sign of the operand (1 = negative) |
| in_mag | input | INT_W+FRAC_W+EXT_W | Operand magnitude with extra low bits |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Sign of the result |
| out_sig | output | INT_W+FRAC_W | Rounded magnitude |
| out_inexact | output | 1 | Discarded bits were nonzero |
| out_carry | output | 1 | Increment overflowed; renormalise |

## Verification
The assertions compare each result with the input beat taken one cycle earlier. They assume the producer holds its fields steady only in the cycle of acceptance and that the mode pin is meaningful only in that cycle. The stimulus sets mode, sign and magnitude in the same cycle as `in_valid`, then replaces them with random values once the beat has been accepted. The consumer stalls for a random number of cycles so that the hold rule is exercised. Random magnitudes are biased toward exact halves, all-ones kept fields and zero discarded fields, so that the tie, carry and exact cases come up often.

// File: rtl/round_pkg.sv
package round_pkg;

  typedef enum logic [1:0] {
    RM_NEAR_EVEN = 2'b00,
    RM_TO_NEG    = 2'b01,
    RM_TO_POS    = 2'b10,
    RM_TO_ZERO   = 2'b11
  } rmode_e;

  typedef struct packed {
    logic lsb;  // last kept bit
    logic rnd;  // first discarded bit
    logic stk;  // OR of everything below rnd
  } grs_t;

endpackage

// File: rtl/round_grs_split.sv
module round_grs_split
  import round_pkg::*;
#(
  parameter int SIG_W = 9,
  parameter int EXT_W = 6,
  localparam int IN_W = SIG_W + EXT_W
) (
  input  logic [IN_W-1:0]  mag,
  output logic [SIG_W-1:0] kept,
  output grs_t             grs,
  output logic             inexact
);

  logic sticky;

  assign kept = mag[IN_W-1:EXT_W];

  generate
    if (EXT_W >= 2) begin : g_wide
      assign sticky = |mag[EXT_W-2:0];
    end else begin : g_single
      assign sticky = 1'b0;
    end
  endgenerate

  assign grs.lsb = mag[EXT_W];
  assign grs.rnd = mag[EXT_W-1];
  assign grs.stk = sticky;
  assign inexact = grs.rnd | sticky;

endmodule

// File: rtl/round_inc_decide.sv
module round_inc_decide
  import round_pkg::*;
(
  input  rmode_e mode,
  input  logic   sign,
  input  grs_t   grs,
  output logic   inc
);

  logic lost;
  assign lost = grs.rnd | grs.stk;

  always_comb begin
    unique case (mode)
      RM_NEAR_EVEN: inc = grs.rnd & (grs.stk | grs.lsb);
      RM_TO_NEG:    inc = lost & sign;
      RM_TO_POS:    inc = lost & ~sign;
      default:      inc = 1'b0;
    endcase
  end

endmodule

// File: rtl/round_inc_apply.sv
module round_inc_apply #(
  parameter int SIG_W = 9
) (
  input  logic [SIG_W-1:0] kept,
  input  logic             inc,
  output logic [SIG_W-1:0] sig,
  output logic             carry
);

  logic [SIG_W:0] sum;

  assign sum   = {1'b0, kept} + {{SIG_W{1'b0}}, inc};
  assign carry = sum[SIG_W];
  assign sig   = carry ? sum[SIG_W:1] : sum[SIG_W-1:0];

endmodule

// File: rtl/round_out_stage.sv
module round_out_stage #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  a_r10_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_drain_or_refill: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

endmodule

// File: rtl/round_unit.sv
module round_unit
  import round_pkg::*;
#(
  parameter int INT_W  = 1,
  parameter int FRAC_W = 8,
  parameter int EXT_W  = 6,
  localparam int SIG_W = INT_W + FRAC_W,
  localparam int IN_W  = SIG_W + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rnd_mode,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [IN_W-1:0]  in_mag,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             out_sign,
  output logic [SIG_W-1:0] out_sig,
  output logic             out_inexact,
  output logic             out_carry
);

  localparam int DATA_W = SIG_W + 3;
  localparam logic [SIG_W-1:0] RENORM_SIG = {1'b1, {(SIG_W-1){1'b0}}};

  logic [SIG_W-1:0]  kept;
  grs_t              grs;
  logic              lost;
  logic              inc;
  logic [SIG_W-1:0]  rsig;
  logic              rcarry;
  logic [DATA_W-1:0] stage_in;
  logic [DATA_W-1:0] stage_out;

  round_grs_split #(.SIG_W(SIG_W), .EXT_W(EXT_W)) u_split (
    .mag(in_mag), .kept(kept), .grs(grs), .inexact(lost)
  );

  round_inc_decide u_decide (
    .mode(rmode_e'(rnd_mode)), .sign(in_sign), .grs(grs), .inc(inc)
  );

  round_inc_apply #(.SIG_W(SIG_W)) u_apply (
    .kept(kept), .inc(inc), .sig(rsig), .carry(rcarry)
  );

  assign stage_in = {in_sign, rcarry, lost, rsig};

  round_out_stage #(.DATA_W(DATA_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(stage_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(stage_out)
  );

  assign out_sign    = stage_out[DATA_W-1];
  assign out_carry   = stage_out[DATA_W-2];
  assign out_inexact = stage_out[DATA_W-3];
  assign out_sig     = stage_out[SIG_W-1:0];

  // Port-level checks across the output register.
  logic acc;
  assign acc = in_valid && in_ready;

  a_r2_exact_passes: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_mag[EXT_W-1:0] == '0) |=>
      (out_valid && out_sig == $past(in_mag[IN_W-1:EXT_W]) && !out_inexact && !out_carry));

  a_r4_zero_truncates: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rnd_mode == RM_TO_ZERO) |=>
      (out_sig == $past(in_mag[IN_W-1:EXT_W]) && !out_carry));

  a_r5_pos_mode_neg_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rnd_mode == RM_TO_POS && in_sign) |=>
      (out_sig == $past(in_mag[IN_W-1:EXT_W]) && !out_carry));

  a_r6_neg_mode_pos_trunc: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && rnd_mode == RM_TO_NEG && !in_sign) |=>
      (out_sig == $past(in_mag[IN_W-1:EXT_W]) && !out_carry));

  a_r7_inexact_flag: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_inexact == $past(|in_mag[EXT_W-1:0])));

  a_r8_carry_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_carry) |-> (out_sig == RENORM_SIG && out_inexact));

  a_r9_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_sign == $past(in_sign)));

endmodule

// File: tb/sim_round_unit.sv
module sim_round_unit;

  localparam int INT_W  = 1;
  localparam int FRAC_W = 8;
  localparam int EXT_W  = 6;
  localparam int SIG_W  = INT_W + FRAC_W;
  localparam int IN_W   = SIG_W + EXT_W;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       rnd_mode = 2'b00;
  logic             in_valid = 1'b0;
  logic             in_ready;
  logic             in_sign = 1'b0;
  logic [IN_W-1:0]  in_mag = '0;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic             out_sign;
  logic [SIG_W-1:0] out_sig;
  logic             out_inexact;
  logic             out_carry;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  round_unit #(.INT_W(INT_W), .FRAC_W(FRAC_W), .EXT_W(EXT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .rnd_mode(rnd_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_sign(in_sign), .in_mag(in_mag),
    .out_valid(out_valid), .out_ready(out_ready), .out_sign(out_sign),
    .out_sig(out_sig), .out_inexact(out_inexact), .out_carry(out_carry)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected {valid, sign, carry, inexact, sig} from the requirements.
  function automatic logic [SIG_W+3:0] model(input logic s, input logic [IN_W-1:0] m, input logic [1:0] md);
    logic [SIG_W-1:0] k;
    logic r, st, x, up;
    logic [SIG_W:0] sum;
    logic [SIG_W-1:0] sg;
    k  = m[IN_W-1:EXT_W];
    r  = m[EXT_W-1];
    st = (m[EXT_W-2:0] != '0);
    x  = r | st;
    case (md)
      2'b00: up = r && (st || k[0]);
      2'b01: up = x && s;
      2'b10: up = x && !s;
      default: up = 1'b0;
    endcase
    sum = {1'b0, k} + (up ? 1 : 0);
    sg  = sum[SIG_W] ? {1'b1, {(SIG_W-1){1'b0}}} : sum[SIG_W-1:0];
    return {1'b1, s, sum[SIG_W], x, sg};
  endfunction

  task automatic beat(input logic s, input logic [IN_W-1:0] m, input logic [1:0] md,
                      input int stall, input string req);
    logic [SIG_W+3:0] e;
    logic [SIG_W+3:0] a;
    e = model(s, m, md);
    @(negedge clk);
    in_valid = 1'b1; in_sign = s; in_mag = m; rnd_mode = md; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    in_sign = 1'($urandom); in_mag = IN_W'($urandom); rnd_mode = 2'($urandom);
    a = {out_valid, out_sign, out_carry, out_inexact, out_sig};
    chk(a == e, req, a, e);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      a = {out_valid, out_sign, out_carry, out_inexact, out_sig};
      chk(a == e, "R10 hold", a, e);
      chk(in_ready == 1'b0, "R10 ready low", in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0, "R10 drain", out_valid, 0);
  endtask

  // Build a magnitude from kept bits and discarded bits.
  function automatic logic [IN_W-1:0] mk(input logic [SIG_W-1:0] k, input logic [EXT_W-1:0] x);
    return {k, x};
  endfunction

  localparam logic [EXT_W-1:0] HALF = {1'b1, {(EXT_W-1){1'b0}}};
  localparam logic [EXT_W-1:0] ABOVE_HALF = {1'b1, {(EXT_W-2){1'b0}}, 1'b1};
  localparam logic [SIG_W-1:0] ONES = '1;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [SIG_W-1:0] k;
    logic [EXT_W-1:0] x;
    void'($urandom(32'd20261211));
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R11 out_valid after release", out_valid, 0);
    chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);

    // +1.0111-like pattern: kept LSB 1, exact half below.
    k = {1'b1, {(SIG_W-3){1'b0}}, 2'b11};
    beat(1'b0, mk(k, HALF), 2'b11, 0, "R4 pos half trunc");
    beat(1'b0, mk(k, HALF), 2'b10, 0, "R5 pos half up");
    beat(1'b0, mk(k, HALF), 2'b01, 0, "R6 pos half down");
    beat(1'b0, mk(k, HALF), 2'b00, 0, "R3 pos half odd->even up");
    beat(1'b1, mk(k, HALF), 2'b11, 0, "R4 neg half trunc");
    beat(1'b1, mk(k, HALF), 2'b10, 0, "R5 neg half toward +inf");
    beat(1'b1, mk(k, HALF), 2'b01, 0, "R6 neg half toward -inf");
    beat(1'b1, mk(k, HALF), 2'b00, 0, "R3 neg half nearest");
    // Tie with even LSB stays; above half always goes up.
    beat(1'b0, mk({k[SIG_W-1:1], 1'b0}, HALF), 2'b00, 1, "R3 tie even stays");
    beat(1'b0, mk({k[SIG_W-1:1], 1'b0}, ABOVE_HALF), 2'b00, 0, "R3 above half up");
    beat(1'b0, mk(k, {1'b0, {(EXT_W-1){1'b1}}}), 2'b00, 0, "R3 below half stays");
    // Carry-out on all-ones.
    beat(1'b0, mk(ONES, ABOVE_HALF), 2'b00, 2, "R8 carry nearest");
    beat(1'b1, mk(ONES, {{(EXT_W-1){1'b0}}, 1'b1}), 2'b01, 0, "R8 carry toward -inf");
    beat(1'b0, mk(ONES, {{(EXT_W-1){1'b0}}, 1'b1}), 2'b01, 0, "R8 no carry positive down");
    // Exact values in every mode.
    for (int md = 0; md < 4; md++)
      beat(1'b1, mk(ONES, '0), 2'(md), 0, "R2 exact all modes");
    beat(1'b0, '0, 2'b10, 0, "R7 zero exact");
    beat(1'b1, mk('0, {{(EXT_W-1){1'b0}}, 1'b1}), 2'b01, 0, "R1 R7 tiny negative down");

    for (int n = 0; n < 400; n++) begin
      k = SIG_W'($urandom);
      x = EXT_W'($urandom);
      case ($urandom % 8)
        0: x = HALF;
        1: k = ONES;
        2: x = '0;
        default: ;
      endcase
      beat(1'($urandom), mk(k, x), 2'($urandom), int'($urandom % 3), "R1 R9 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule